// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog built on a free-running 64-bit time base. The count advances by one on every cycle in which the tick-enable input is high. Software can also load the count directly, one 32-bit half at a time. A 2-bit period field selects one of four bits of the count. Each 0-to-1 transition of the selected bit is a watchdog event. This covers a transition caused by a software load as well as one caused by counting.

Every event advances a small arming machine held in two status flags, arm and interrupt-pending:

- The first event after software has cleared the arm flag only sets the arm flag again.
- The next event sets interrupt-pending. This raises the critical interrupt request, provided both the local enable and the external critical-interrupt enable are high.
- A further event that arrives while both flags are still set produces a one-cycle reset request, provided the sticky reset-mode field is nonzero.

Software keeps the system alive by clearing the flags, which are write-one-to-clear. The interrupt vectoring and the reset sequencing that consume the two requests sit outside this block.

Top module: `wdt_unit`

## Requirements
- R1: An event is recognised only when the selected count bit is 1 and was 0 in the previous cycle. A steady 1, a steady 0 and a 1-to-0 transition change no flag and raise no reset request.
- R2: A load of the low half of the count that turns the selected bit from 0 to 1 is an event, exactly like an increment.
- R3: Period field values 0, 1, 2 and 3 select count bits 20, 24, 28 and 32 (LSB = bit 0). Rising edges on any bit that is not selected are ignored.
- R4: On an event with the arm flag clear (status bit 0 = 0), the arm flag is set and interrupt-pending (status bit 1) keeps its value.
- R5: On an event with arm = 1 and interrupt-pending = 0, interrupt-pending is set.
- R6: `irq_o` is 1 exactly when interrupt-pending, the interrupt-enable control bit and `crit_en_i` are all 1.
- R7: After software clears both flags, the first event only sets arm and the second event sets interrupt-pending. The interrupt therefore comes between one and two periods after the clear.
- R8: On an event with both flags set, `rst_req_o` is high for exactly one cycle if the reset-mode field is nonzero, and stays low if it is zero.
- R9: Once the reset-mode field holds a nonzero value, control writes cannot change it. Only reset returns it to zero.
- R10: Writing a 1 to status bit 0 or bit 1 with `stat_clr_i` clears that flag. When an event sets a flag in the same cycle as a clear of that flag, the set wins.
- R11: The count increments when `tick_en_i` is high. A low-half load replaces bits 31:0 and produces no carry into bits 63:32 in that cycle. A high-half load replaces bits 63:32. A load takes priority over the increment for the half it writes.
- R12: After reset, the count, both flags, the period field, the interrupt enable and the reset-mode field are all zero, and no event occurs in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Count advance enable |
| tb_lo_we_i | input | 1 | Load bits 31:0 of the count |
| tb_hi_we_i | input | 1 | Load bits 63:32 of the count |
| tb_wdata_i | input | 32 | Load data for the count halves |
| ctrl_we_i | input | 1 | Control field write strobe |
| ctrl_period_i | input | 2 | Period select write data |
| ctrl_irq_en_i | input | 1 | Interrupt enable write data |
| ctrl_rst_mode_i | input | 2 | Reset-mode write data (sticky once nonzero) |
| stat_clr_i | input | 1 | Status write-one-to-clear strobe |
| stat_clr_mask_i | input | 2 | Bit 0 clears arm, bit 1 clears interrupt-pending |
| crit_en_i | input | 1 | External critical-interrupt enable |
| time_base_o | output | 64 | Current count |
| status_o | output | 2 | Bit 0 arm, bit 1 interrupt-pending |
| rst_mode_o | output | 2 | Current reset-mode field |
| irq_o | output | 1 | Critical interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions check the following on every cycle:

- each single-step transition of the arming machine;
- that the reset-mode field stays fixed once it is nonzero;
- that a reset request appears only one cycle after an event with both flags set;
- that the count advances by exactly one, and that the upper half is held during a low-half load.

Some behaviours depend on chosen values of the count and on the order of events, so only the bench's scenarios can show them:

- which count bit each period value selects;
- that a falling or steady level produces no event;
- that a software load can create an event;
- the set-over-clear priority;
- the arm-then-interrupt spacing after a clear.

The bench reaches these cases by loading the count close to each selected bit instead of waiting up to 2^33 ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned TB_W     = 64;
  localparam int unsigned HALF_W   = TB_W / 2;
  localparam int unsigned PER_W    = 2;
  localparam int unsigned N_SEL    = 1 << PER_W;
  localparam int unsigned SEL_BASE = 20;
  localparam int unsigned SEL_STEP = 4;
  localparam int unsigned RMODE_W  = 2;

  typedef struct packed {
    logic [PER_W-1:0]   period;
    logic               irq_en;
    logic [RMODE_W-1:0] rst_mode;
  } wdt_ctrl_t;

  typedef struct packed {
    logic pend;
    logic arm;
  } wdt_stat_t;
endpackage

// File: rtl/wdt_time_base.sv
module wdt_time_base
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [TB_W-1:0]   tb_o
);
  logic [TB_W-1:0] tb_q, inc_w, tb_d;

  always_comb begin
    inc_w = tb_q + TB_W'(tick_en_i);
    tb_d  = inc_w;
    if (lo_we_i) begin
      tb_d[HALF_W-1:0]    = wdata_i;
      tb_d[TB_W-1:HALF_W] = tb_q[TB_W-1:HALF_W];  // no carry on low load
    end
    if (hi_we_i) tb_d[TB_W-1:HALF_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tb_q <= '0;
    else         tb_q <= tb_d;
  end

  assign tb_o = tb_q;

  AST_TB_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_en_i && !lo_we_i && !hi_we_i) |=> (tb_q == $past(tb_q) + 1'b1)); // R11
  AST_LO_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !hi_we_i) |=> (tb_q[TB_W-1:HALF_W] == $past(tb_q[TB_W-1:HALF_W]))); // R11
endmodule

// File: rtl/wdt_edge_sel.sv
module wdt_edge_sel
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TB_W-1:0]  tb_i,
  input  logic [PER_W-1:0] period_i,
  output logic             evt_o
);
  logic [N_SEL-1:0] cand_w;
  logic             bit_w, prev_q;

  for (genvar g = 0; g < N_SEL; g++) begin : g_tap
    assign cand_w[g] = tb_i[SEL_BASE + g*SEL_STEP];
  end

  assign bit_w = cand_w[period_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= bit_w;
  end

  assign evt_o = bit_w & ~prev_q;

  AST_EVT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && $stable(period_i)) |-> !$past(bit_w)); // R1
endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PER_W-1:0]   period_i,
  input  logic               irq_en_i,
  input  logic [RMODE_W-1:0] rst_mode_i,
  output wdt_ctrl_t          ctrl_o
);
  wdt_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i) begin
      ctrl_q.period <= period_i;
      ctrl_q.irq_en <= irq_en_i;
      if (ctrl_q.rst_mode == '0) ctrl_q.rst_mode <= rst_mode_i;  // sticky once set
    end
  end

  assign ctrl_o = ctrl_q;

  AST_RMODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.rst_mode != '0) |=> $stable(ctrl_q.rst_mode)); // R9
endmodule

// File: rtl/wdt_status_fsm.sv
module wdt_status_fsm
  import wdt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_i,
  input  logic               clr_i,
  input  logic [1:0]         clr_mask_i,
  input  logic [RMODE_W-1:0] rst_mode_i,
  output wdt_stat_t          stat_o,
  output logic               rst_req_o
);
  wdt_stat_t stat_q, stat_d;
  logic      rst_req_q, rst_req_d;

  always_comb begin
    stat_d.arm  = stat_q.arm  & ~(clr_i & clr_mask_i[0]);
    stat_d.pend = stat_q.pend & ~(clr_i & clr_mask_i[1]);
    rst_req_d   = 1'b0;
    if (evt_i) begin
      // set beats a same-cycle clear
      if (!stat_q.arm)       stat_d.arm  = 1'b1;
      else if (!stat_q.pend) stat_d.pend = 1'b1;
      else                   rst_req_d   = (rst_mode_i != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q    <= '0;
      rst_req_q <= 1'b0;
    end else begin
      stat_q    <= stat_d;
      rst_req_q <= rst_req_d;
    end
  end

  assign stat_o    = stat_q;
  assign rst_req_o = rst_req_q;

  AST_ARM_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !stat_q.arm && !stat_q.pend) |=> (stat_q.arm && !stat_q.pend)); // R4
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && stat_q.arm && !stat_q.pend) |=> stat_q.pend); // R5
  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(evt_i && stat_q.arm && stat_q.pend && (rst_mode_i != '0))); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !stat_q.arm && clr_i && clr_mask_i[0]) |=> stat_q.arm); // R10
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_en_i,
  input  logic        tb_lo_we_i,
  input  logic        tb_hi_we_i,
  input  logic [31:0] tb_wdata_i,
  input  logic        ctrl_we_i,
  input  logic [1:0]  ctrl_period_i,
  input  logic        ctrl_irq_en_i,
  input  logic [1:0]  ctrl_rst_mode_i,
  input  logic        stat_clr_i,
  input  logic [1:0]  stat_clr_mask_i,
  input  logic        crit_en_i,
  output logic [63:0] time_base_o,
  output logic [1:0]  status_o,
  output logic [1:0]  rst_mode_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic [TB_W-1:0] tb_w;
  logic            evt_w;
  wdt_ctrl_t       ctrl_w;
  wdt_stat_t       stat_w;

  wdt_time_base u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en_i),
    .lo_we_i(tb_lo_we_i), .hi_we_i(tb_hi_we_i), .wdata_i(tb_wdata_i), .tb_o(tb_w)
  );

  wdt_ctrl_regs u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ctrl_we_i), .period_i(ctrl_period_i),
    .irq_en_i(ctrl_irq_en_i), .rst_mode_i(ctrl_rst_mode_i), .ctrl_o(ctrl_w)
  );

  wdt_edge_sel u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .tb_i(tb_w), .period_i(ctrl_w.period), .evt_o(evt_w)
  );

  wdt_status_fsm u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_w), .clr_i(stat_clr_i),
    .clr_mask_i(stat_clr_mask_i), .rst_mode_i(ctrl_w.rst_mode),
    .stat_o(stat_w), .rst_req_o(rst_req_o)
  );

  assign time_base_o = tb_w;
  assign status_o    = {stat_w.pend, stat_w.arm};
  assign rst_mode_o  = ctrl_w.rst_mode;
  assign irq_o       = stat_w.pend & ctrl_w.irq_en & crit_en_i;

  AST_NO_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] |-> !irq_o); // R6
endmodule

// File: tb/wdt_unit_tb_top.sv
module wdt_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0, tb_lo_we_i = 1'b0, tb_hi_we_i = 1'b0;
  logic [31:0] tb_wdata_i = '0;
  logic        ctrl_we_i = 1'b0, ctrl_irq_en_i = 1'b0;
  logic [1:0]  ctrl_period_i = '0, ctrl_rst_mode_i = '0;
  logic        stat_clr_i = 1'b0;
  logic [1:0]  stat_clr_mask_i = '0;
  logic        crit_en_i = 1'b0;
  logic [63:0] time_base_o;
  logic [1:0]  status_o, rst_mode_o;
  logic        irq_o, rst_req_o;

  int n_vec = 0, n_bad = 0, rst_cnt = 0, cyc_cnt = 0;

  always #4 clk_i = ~clk_i;

  wdt_unit dut_i (.*);

  // behavioural reference
  logic [63:0] m_tb;
  logic        m_prev, m_arm, m_pend, m_ien, m_rreq;
  logic [1:0]  m_per, m_rmode;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tb = '0; m_prev = 0; m_arm = 0; m_pend = 0; m_ien = 0; m_rreq = 0;
      m_per = '0; m_rmode = '0;
    end else begin
      logic        sel, ev, na, np;
      logic [63:0] t;
      sel = m_tb[20 + 4*int'(m_per)];
      ev  = sel && !m_prev;
      na  = m_arm  && !(stat_clr_i && stat_clr_mask_i[0]);
      np  = m_pend && !(stat_clr_i && stat_clr_mask_i[1]);
      m_rreq = 0;
      if (ev) begin
        if (!m_arm) na = 1;
        else if (!m_pend) np = 1;
        else m_rreq = (m_rmode != 0);
      end
      t = m_tb + (tick_en_i ? 64'd1 : 64'd0);
      if (tb_lo_we_i) t = {m_tb[63:32], tb_wdata_i};
      if (tb_hi_we_i) t[63:32] = tb_wdata_i;
      if (ctrl_we_i) begin
        m_per = ctrl_period_i; m_ien = ctrl_irq_en_i;
        if (m_rmode == 0) m_rmode = ctrl_rst_mode_i;
      end
      m_prev = sel; m_tb = t; m_arm = na; m_pend = np;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compare every cycle, after the edge settles
  always begin
    @(posedge clk_i); #1;
    if (rst_ni) begin
      cyc_cnt++;
      if (rst_req_o) rst_cnt++;
      chk("R11 time base", time_base_o, m_tb);
      chk("R4 status", 64'(status_o), 64'({m_pend, m_arm}));
      chk("R9 rst mode", 64'(rst_mode_o), 64'(m_rmode));
      chk("R6 irq", 64'(irq_o), 64'(m_pend & m_ien & crit_en_i));
      chk("R8 rst req", 64'(rst_req_o), 64'(m_rreq));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_lo(input logic [31:0] d);
    @(negedge clk_i); tb_lo_we_i = 1; tb_wdata_i = d;
    @(negedge clk_i); tb_lo_we_i = 0;
    cyc(2);
  endtask

  task automatic wr_hi(input logic [31:0] d);
    @(negedge clk_i); tb_hi_we_i = 1; tb_wdata_i = d;
    @(negedge clk_i); tb_hi_we_i = 0;
    cyc(2);
  endtask

  task automatic wr_ctrl(input logic [1:0] per, input logic ien, input logic [1:0] rm);
    @(negedge clk_i); ctrl_we_i = 1; ctrl_period_i = per; ctrl_irq_en_i = ien; ctrl_rst_mode_i = rm;
    @(negedge clk_i); ctrl_we_i = 0;
    cyc(1);
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk_i); stat_clr_i = 1; stat_clr_mask_i = m;
    @(negedge clk_i); stat_clr_i = 0;
    cyc(1);
  endtask

  task automatic tick1();
    @(negedge clk_i); tick_en_i = 1;
    @(negedge clk_i); tick_en_i = 0;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(2);
    chk("R12 reset tb", time_base_o, 64'd0);
    chk("R12 reset status", 64'(status_o), 64'd0);
    chk("R12 reset rmode", 64'(rst_mode_o), 64'd0);

    wr_lo(32'h0010_0000);
    chk("R4 first event arms only", 64'(status_o), 64'd1);
    wr_lo(32'h0);
    chk("R1 falling edge ignored", 64'(status_o), 64'd1);
    wr_lo(32'h0010_0000);
    chk("R2 load creates event", 64'(status_o), 64'd3);
    chk("R5 pending set", 64'(status_o[1]), 64'd1);

    wr_ctrl(2'd0, 1'b0, 2'd2);
    rst_cnt = 0;
    wr_lo(32'h0010_0000);
    chk("R1 steady level ignored", 64'(rst_cnt), 64'd0);
    wr_lo(32'h0);
    wr_lo(32'h0010_0000);
    chk("R8 single reset pulse", 64'(rst_cnt), 64'd1);

    wr_ctrl(2'd0, 1'b1, 2'd0);
    chk("R9 sticky reset mode", 64'(rst_mode_o), 64'd2);
    @(negedge clk_i); crit_en_i = 1; cyc(1);
    chk("R6 irq asserted", 64'(irq_o), 64'd1);
    @(negedge clk_i); crit_en_i = 0; cyc(1);
    chk("R6 irq gated by crit enable", 64'(irq_o), 64'd0);

    clr(2'b11);
    chk("R10 w1c clears both", 64'(status_o), 64'd0);

    wr_lo(32'h0); wr_lo(32'h0010_0000);
    chk("R7 first event after clear", 64'(status_o), 64'd1);
    wr_lo(32'h0); wr_lo(32'h0010_0000);
    chk("R7 second event interrupts", 64'(status_o), 64'd3);

    clr(2'b11);
    wr_lo(32'h0);
    @(negedge clk_i); tb_lo_we_i = 1; tb_wdata_i = 32'h0010_0000;
    @(negedge clk_i); tb_lo_we_i = 0; stat_clr_i = 1; stat_clr_mask_i = 2'b01;
    @(negedge clk_i); stat_clr_i = 0;
    cyc(2);
    chk("R10 set wins over clear", 64'(status_o), 64'd1);

    clr(2'b11);
    wr_lo(32'h0);
    wr_ctrl(2'd1, 1'b1, 2'd0);
    wr_lo(32'h0010_0000);
    chk("R3 unselected bit 20 ignored", 64'(status_o), 64'd0);
    wr_lo(32'h00FF_FFFF);
    tick1();
    chk("R11 tick increment", time_base_o, 64'h0100_0000);
    cyc(2);
    chk("R3 bit 24 selected", 64'(status_o), 64'd1);

    clr(2'b11);
    wr_lo(32'h0);
    wr_ctrl(2'd3, 1'b1, 2'd0);
    wr_hi(32'h6);
    @(negedge clk_i); tick_en_i = 1; tb_lo_we_i = 1; tb_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i); tick_en_i = 0; tb_lo_we_i = 0;
    chk("R11 low load no carry", time_base_o, 64'h6_FFFF_FFFF);
    tick1();
    chk("R11 carry into high half", time_base_o, 64'h7_0000_0000);
    cyc(2);
    chk("R3 bit 32 selected", 64'(status_o), 64'd1);

    @(negedge clk_i); tick_en_i = 1;
    cyc(5);
    tick_en_i = 0;
    chk("R11 five ticks", time_base_o, 64'h7_0000_0005);

    @(negedge clk_i); rst_ni = 0;
    cyc(2); rst_ni = 1; cyc(2);
    chk("R12 reset tb again", time_base_o, 64'd0);
    chk("R12 reset status again", 64'(status_o), 64'd0);
    chk("R12 reset rmode again", 64'(rst_mode_o), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule